// File: doc/BRIEF.md
# SIMD Absolute-Difference Accumulate-Long Unit

This block is a lane-partitioned integer datapath. It takes two 64-bit source vectors and a 128-bit accumulator vector. A size code splits the sources into equal lanes of 8, 16 or 32 bits. For every lane it forms the absolute difference of the two source elements and widens it to twice the lane width. It then adds that value into the double-width accumulator lane with the same index. The updated 128-bit accumulator comes back one clock after a start strobe, together with a one-cycle valid pulse.

A signedness input chooses whether the source elements are read as unsigned or as two's-complement values. Each accumulate wraps inside its own lane. A reserved size code is reported on an illegal-size output, and in that case the accumulator passes through unchanged. The unit produces no condition flags.

Top module: `absdiff_acc_unit`

## Requirements
- R1: Source lane i occupies bits [i*E +: E] of each source, and result lane i occupies bits [i*2E +: 2E] of the accumulator and of the result, where E is the element width.
- R2: The size code sizeSel selects E: 2'b00 gives 8 bits (8 lanes), 2'b01 gives 16 bits (4 lanes) and 2'b10 gives 32 bits (2 lanes).
- R3: Each result lane equals the accumulator lane plus |srcA lane − srcB lane|, zero-extended to 2E bits. When the operands are equal, the accumulator comes back unchanged.
- R4: When isUnsigned is 1, the elements are unsigned. When it is 0, they are two's-complement signed. The difference is exact for every pair, so the magnitude can reach 2^E − 1 (8-bit signed 0x7F against 0x80 gives 255; 8-bit signed 0xFF against 0x01 gives 2, while unsigned gives 254).
- R5: The accumulate wraps modulo 2^(2E) inside each lane. No carry reaches a neighbouring lane.
- R6: A start sampled at a rising edge updates result at that edge and raises resultValid for exactly one cycle. Without start, resultValid is 0 and result holds its value.
- R7: sizeSel 2'b11 is reserved. On a start with that code, result takes accIn unchanged and illegalSize becomes 1. illegalSize is updated on every start and holds its value between starts.
- R8: A synchronous active-high reset clears result, resultValid and illegalSize to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts one operation on the current operands |
| sizeSel | input | 2 | Element width code (00=8, 01=16, 10=32, 11 reserved) |
| isUnsigned | input | 1 | 1 = unsigned elements, 0 = signed elements |
| srcA | input | 64 | First source vector (minuend) |
| srcB | input | 64 | Second source vector (subtrahend) |
| accIn | input | 128 | Accumulator vector of double-width lanes |
| result | output | 128 | Registered updated accumulator |
| resultValid | output | 1 | One-cycle pulse when result is new |
| illegalSize | output | 1 | Set when the last start used the reserved size code |

## Verification
The unit is tried with random operands for each of the three sizes in both signedness modes, and the result is compared against a per-lane model, which separates the lane layouts and widths. Equal operands show that no stray value enters the sum. Directed pairs at the extremes of the element range, such as 0x7F against 0x80 and 0xFF against 0x01, separate the signed from the unsigned interpretation and show that the difference has no lost bit. An all-ones accumulator lane next to a known neighbour shows wrap-around without a carry crossing lanes. The reserved size code shows the pass-through and the flag.

// File: rtl/absacc_pkg.sv
package absacc_pkg;
  localparam int SIZE_W = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;       // capture a new result this edge
    logic passThrough;  // reserved size: forward the accumulator
  } absacc_strobe_t;
endpackage

// File: rtl/absacc_lane.sv
module absacc_lane #(
  parameter int ELEM_W = 8
) (
  input  logic [ELEM_W-1:0]   elemA,
  input  logic [ELEM_W-1:0]   elemB,
  input  logic                isUnsigned,
  input  logic [2*ELEM_W-1:0] accLane,
  output logic [2*ELEM_W-1:0] sumLane
);
  localparam int EXT_W = ELEM_W + 1;

  logic [EXT_W-1:0] extA, extB, diff, negDiff;
  logic [ELEM_W-1:0] magnitude;

  // one guard bit keeps the difference exact in both modes
  assign extA    = {~isUnsigned & elemA[ELEM_W-1], elemA};
  assign extB    = {~isUnsigned & elemB[ELEM_W-1], elemB};
  assign diff    = extA - extB;
  assign negDiff = extB - extA;
  assign magnitude = diff[EXT_W-1] ? negDiff[ELEM_W-1:0] : diff[ELEM_W-1:0];

  // sum confined to this lane: wraps modulo 2^(2*ELEM_W)
  assign sumLane = accLane + {{ELEM_W{1'b0}}, magnitude};
endmodule

// File: rtl/absacc_ctrl.sv
module absacc_ctrl
  import absacc_pkg::*;
#(
  parameter int NUM_SIZES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] sizeSel,
  output absacc_strobe_t    strobes,
  output logic              resultValid,
  output logic              illegalSize
);
  logic sizeReserved;

  assign sizeReserved = (int'(sizeSel) >= NUM_SIZES);

  always_comb begin
    strobes.loadEn      = start;
    strobes.passThrough = sizeReserved;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      illegalSize <= 1'b0;
    end else begin
      resultValid <= start;
      if (start) illegalSize <= sizeReserved;
    end
  end
endmodule

// File: rtl/absacc_dpath.sv
module absacc_dpath
  import absacc_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int MIN_ELEM_W = 8,
  parameter int NUM_SIZES  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  absacc_strobe_t    strobes,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              isUnsigned,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [2*DATA_W-1:0] accIn,
  output logic [2*DATA_W-1:0] result
);
  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] variantSum [NUM_SIZES];
  logic [ACC_W-1:0] nextResult;

  // one full lane array per selectable element width
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int ELEM_W = MIN_ELEM_W << k;
    localparam int LANES  = DATA_W / ELEM_W;
    logic [ACC_W-1:0] laneSums;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      absacc_lane #(.ELEM_W(ELEM_W)) u_lane (
        .elemA     (srcA[i*ELEM_W +: ELEM_W]),
        .elemB     (srcB[i*ELEM_W +: ELEM_W]),
        .isUnsigned(isUnsigned),
        .accLane   (accIn[i*2*ELEM_W +: 2*ELEM_W]),
        .sumLane   (laneSums[i*2*ELEM_W +: 2*ELEM_W])
      );
    end
    assign variantSum[k] = laneSums;
  end

  always_comb begin
    nextResult = accIn;
    if (!strobes.passThrough) begin
      for (int k = 0; k < NUM_SIZES; k++) begin
        if (sizeSel == SIZE_W'(k)) nextResult = variantSum[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobes.loadEn) result <= nextResult;
  end
endmodule

// File: rtl/absdiff_acc_unit.sv
module absdiff_acc_unit
  import absacc_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int MIN_ELEM_W = 8,
  parameter int NUM_SIZES  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          sizeSel,
  input  logic                isUnsigned,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W-1:0]   srcB,
  input  logic [2*DATA_W-1:0] accIn,
  output logic [2*DATA_W-1:0] result,
  output logic                resultValid,
  output logic                illegalSize
);
  absacc_strobe_t strobes;

  absacc_ctrl #(.NUM_SIZES(NUM_SIZES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sizeSel    (sizeSel),
    .strobes    (strobes),
    .resultValid(resultValid),
    .illegalSize(illegalSize)
  );

  absacc_dpath #(
    .DATA_W    (DATA_W),
    .MIN_ELEM_W(MIN_ELEM_W),
    .NUM_SIZES (NUM_SIZES)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .sizeSel   (sizeSel),
    .isUnsigned(isUnsigned),
    .srcA      (srcA),
    .srcB      (srcB),
    .accIn     (accIn),
    .result    (result)
  );
endmodule

// File: rtl/absdiff_acc_checker.sv
module absdiff_acc_checker #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [1:0]          sizeSel,
  input logic [DATA_W-1:0]   srcA,
  input logic [DATA_W-1:0]   srcB,
  input logic [2*DATA_W-1:0] accIn,
  input logic [2*DATA_W-1:0] result,
  input logic                resultValid,
  input logic                illegalSize
);
  // R6: valid is the registered image of start
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    start |=> resultValid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !start |=> !resultValid);
  // R6: result holds between operations
  a_r6_result_holds: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result));
  // R3: equal operands leave the accumulator untouched
  a_r3_equal_operands: assert property (@(posedge clk) disable iff (rst)
    (start && srcA == srcB) |=> result == $past(accIn));
  // R7: reserved size passes the accumulator through and flags it
  a_r7_reserved_passthrough: assert property (@(posedge clk) disable iff (rst)
    (start && sizeSel == 2'b11) |=> (result == $past(accIn) && illegalSize));
  a_r7_legal_clears_flag: assert property (@(posedge clk) disable iff (rst)
    (start && sizeSel != 2'b11) |=> !illegalSize);
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(illegalSize));
endmodule

bind absdiff_acc_unit absdiff_acc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .sizeSel    (sizeSel),
  .srcA       (srcA),
  .srcB       (srcB),
  .accIn      (accIn),
  .result     (result),
  .resultValid(resultValid),
  .illegalSize(illegalSize)
);

// File: tb/absdiff_acc_unit_test.sv
`timescale 1ns/1ps
module absdiff_acc_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   sizeSel = 2'b00;
  logic         isUnsigned = 1'b1;
  logic [63:0]  srcA = '0;
  logic [63:0]  srcB = '0;
  logic [127:0] accIn = '0;
  logic [127:0] result;
  logic         resultValid;
  logic         illegalSize;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  absdiff_acc_unit uut (
    .clk(clk), .rst(rst), .start(start), .sizeSel(sizeSel),
    .isUnsigned(isUnsigned), .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .result(result), .resultValid(resultValid), .illegalSize(illegalSize)
  );

  // per-lane behavioural model
  function automatic logic [127:0] model(logic [63:0] a, logic [63:0] b,
      logic [127:0] acc, logic [1:0] sz, logic uns);
    logic [127:0] r;
    int e;
    if (sz == 2'b11) return acc;
    e = 8 << sz;
    r = '0;
    for (int lane = 0; lane < 64 / e; lane++) begin
      longint xa, xb, d;
      logic [63:0] m1, m2, accL, s;
      m1 = (64'd1 << e) - 64'd1;
      m2 = (e == 32) ? '1 : ((64'd1 << (2 * e)) - 64'd1);
      xa = longint'((a >> (lane * e)) & m1);
      xb = longint'((b >> (lane * e)) & m1);
      if (!uns && xa[e-1]) xa = xa - (longint'(1) << e);
      if (!uns && xb[e-1]) xb = xb - (longint'(1) << e);
      d = xa - xb;
      if (d < 0) d = -d;
      accL = 64'((acc >> (lane * 2 * e)) & {64'd0, m2});
      s = (accL + 64'(d)) & m2;
      r = r | (128'(s) << (lane * 2 * e));
    end
    return r;
  endfunction

  task automatic check128(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive one operation, check at the negedge after the capturing edge
  task automatic doOp(logic [63:0] a, logic [63:0] b, logic [127:0] acc,
      logic [1:0] sz, logic uns, string req);
    @(negedge clk);
    srcA = a; srcB = b; accIn = acc; sizeSel = sz; isUnsigned = uns;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check128(req, result, model(a, b, acc, sz, uns));
    checkBit({req, " R6 valid"}, resultValid, 1'b1);
    checkBit({req, " R7 flag"}, illegalSize, sz == 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check128("R8 result after reset", result, '0);
    checkBit("R8 valid after reset", resultValid, 1'b0);
    checkBit("R8 flag after reset", illegalSize, 1'b0);

    void'($urandom(32'd20240607));

    // R3 equal operands for each size
    for (int s = 0; s < 3; s++) begin
      logic [63:0] v;
      logic [127:0] acc;
      v = {$urandom, $urandom};
      acc = {$urandom, $urandom, $urandom, $urandom};
      doOp(v, v, acc, 2'(s), 1'b0, "R3 equal operands");
      check128("R3 equal operands keep accumulator", result, acc);
    end

    // R4 extreme pairs, 8-bit lanes
    doOp({8{8'h7F}}, {8{8'h80}}, '0, 2'b00, 1'b0, "R4 signed max-min");
    check128("R4 signed max-min literal", result, {8{16'h00FF}});
    doOp({8{8'hFF}}, {8{8'h00}}, '0, 2'b00, 1'b1, "R4 unsigned max-min");
    check128("R4 unsigned max-min literal", result, {8{16'h00FF}});
    doOp({8{8'hFF}}, {8{8'h01}}, '0, 2'b00, 1'b0, "R4 signed -1 vs 1");
    check128("R4 signed -1 vs 1 literal", result, {8{16'h0002}});
    doOp({8{8'hFF}}, {8{8'h01}}, '0, 2'b00, 1'b1, "R4 unsigned 255 vs 1");
    check128("R4 unsigned 255 vs 1 literal", result, {8{16'h00FE}});
    doOp({2{32'h8000_0000}}, {2{32'h7FFF_FFFF}}, '0, 2'b10, 1'b0, "R4 signed 32-bit min-max");
    check128("R4 signed 32-bit literal", result, {2{64'h0000_0000_FFFF_FFFF}});

    // R5 wrap without carry into the neighbour, R1 lane placement
    doOp(64'd1, 64'd0, {96'd0, 16'h1234, 16'hFFFF}, 2'b00, 1'b1, "R5 wrap 8-bit");
    check128("R5 R1 wrap 8-bit literal", result, {96'd0, 16'h1234, 16'h0000});
    doOp(64'd5, 64'd2, {64'h0000_0000_0000_0077, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b10, 1'b1, "R5 wrap 32-bit");
    check128("R5 R1 wrap 32-bit literal", result, {64'h77, 64'h2});
    doOp({16'h0, 16'h0, 16'h0003, 16'h0}, 64'd0, {64'd0, 32'h0000_FFFF, 32'h0}, 2'b01, 1'b1, "R1 lane 1 of 16-bit");
    check128("R1 R2 16-bit lane 1 literal", result, {64'd0, 32'h0001_0002, 32'h0});

    // R7 reserved size
    doOp(64'h1234, 64'h9876, {4{32'hCAFE_F00D}}, 2'b11, 1'b0, "R7 reserved size");
    check128("R7 passthrough literal", result, {4{32'hCAFE_F00D}});

    // R6 idle cycles: valid drops, result and flag hold
    @(negedge clk);
    checkBit("R6 valid drops", resultValid, 1'b0);
    srcA = '1; accIn = '0; sizeSel = 2'b00;
    @(negedge clk);
    check128("R6 result holds without start", result, {4{32'hCAFE_F00D}});
    checkBit("R7 flag holds without start", illegalSize, 1'b1);

    // R1 R2 R3 R4 random operands over every size and signedness
    for (int s = 0; s < 3; s++) begin
      for (int u = 0; u < 2; u++) begin
        for (int n = 0; n < 25; n++) begin
          doOp({$urandom, $urandom}, {$urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, 2'(s), 1'(u),
               "R1 R2 R3 R4 random");
        end
      end
    end

    // R8 reset clears state mid-run
    doOp(64'hFF, 64'h0, '0, 2'b11, 1'b1, "R7 flag set before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check128("R8 result cleared", result, '0);
    checkBit("R8 flag cleared", illegalSize, 1'b0);
    checkBit("R8 valid cleared", resultValid, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule